// File: doc/BRIEF.md
# Fractional-Prescaler Baud Tick Generator

This block turns one fixed input clock into the two timing strobes a serial port needs: a sample strobe for the receiver's oversampling logic and a bit strobe that marks the end of each bit time. The clock passes through three stages in series. The first is a fractional prescaler that divides by a code counted in eighths. The second is a 16-bit integer divisor. The third is an oversampling counter that sets how many sample strobes make up one bit. With a 62.5 MHz input, an oversampling count of 4 and the prescaler and divisor both at 1, the bit rate is 15.625 Mbit/s. Lower rates are reached by trading the three factors against each other, which allows fine steps.

Software programs the block through a small byte-wide register port. The divisor halves, a mode register and an index register sit at direct addresses. The oversampling count, the two prescaler halves and an access-control register are reached indirectly: the index register selects one of them, and the data address then reads or writes it. Every configuration write restarts all three stages from a clean phase, so a new rate takes effect from a known point.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor is 1, the oversampling code is 0, the prescaler code is 0 and the mode register is 0. The bit strobe then repeats every 16 clocks, with 16 sample strobes per bit.
- R2: Oversampling codes 4 to 15 give exactly that many sample strobes per bit. Codes 0 to 3 give 16.
- R3: When the prescaler is enabled, its average output period is code/8 input clocks, and each step adds at most one clock of jitter. As a result, 8 consecutive bit periods span exactly code × divisor × oversampling clocks, and each single bit period differs from code × divisor × oversampling / 8 by less than one clock.
- R4: Prescaler codes 0 to 7 behave as code 8, that is, a factor of 1.000.
- R5: Bit 7 of the mode register (direct address 2) enables the prescaler. When this bit is 0, the prescaler passes every clock, whatever its code.
- R6: The prescaler code is 9 bits wide. Its low 8 bits are in extended index 1 and its top bit is bit 0 of extended index 2. Any write to index 1 clears index 2.
- R7: The divisor is 16 bits: low byte at direct address 0, high byte at direct address 1. A divisor value of 0 behaves as 1. With a divisor of 2 or more, two sample strobes are never adjacent.
- R8: Register map. Direct address 3 holds the extended index and direct address 4 is the extended data port. The extended registers are: index 0 is the oversampling code (bits 3:0), index 1 is the prescaler low part, index 2 is the prescaler high part, and index 3 is access control, where bit 0 enables reads. A read of address 4 returns the selected extended register only while that bit is 1; otherwise it returns 0. Direct addresses 0 to 3 read back their contents. rdata is 0 whenever rd_en is low.
- R9: A configuration write is a write to address 0, 1 or 2, or to extended index 0, 1 or 2. It restarts all counters, and no strobe appears in the following cycle. In bypass mode the first bit strobe then comes exactly divisor × oversampling clocks after the write edge.
- R10: The bit strobe is asserted only together with a sample strobe, on the last sample of each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| sample_tick | output | 1 | One-clock sample strobe |
| bit_tick | output | 1 | One-clock bit strobe, coincident with the last sample |

## Verification
The embedded assertions check on every cycle the properties that hold cycle by cycle:
- the prescaler phase accumulator stays below the effective code;
- both counters stay within their terminal values;
- no strobe follows a configuration write;
- sample strobes are spaced apart when the divisor is 2 or more;
- the bit strobe only ever accompanies a sample strobe;
- a write to the low prescaler part clears the high part.

Other behaviour can only be shown by the bench's sweeps, which measure strobe periods and compare them with products computed arithmetically. These include:
- the exact long-run rate of the fractional prescaler and its bounded jitter;
- the mapping of the low oversampling codes to 16;
- the handling of zero codes for the divisor and the prescaler;
- the bypass mode;
- the read gating of the extended port.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int DIV_W     = 16;
  localparam int OVS_W     = 4;
  localparam int OVS_MIN   = 4;
  localparam int FRAC_BITS = 3;
  localparam int PRE_W     = 9;
  localparam int MODE_PRE_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_DIV_LO = 3'd0,
    A_DIV_HI = 3'd1,
    A_MODE   = 3'd2,
    A_INDEX  = 3'd3,
    A_XDATA  = 3'd4
  } addr_e;

  localparam logic [DATA_W-1:0] X_OVS    = 8'd0;
  localparam logic [DATA_W-1:0] X_PRE_LO = 8'd1;
  localparam logic [DATA_W-1:0] X_PRE_HI = 8'd2;
  localparam logic [DATA_W-1:0] X_ACCESS = 8'd3;
endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
  import frac_baud_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int DVW  = DIV_W,
  parameter int OW   = OVS_W,
  parameter int OMIN = OVS_MIN,
  parameter int PW   = PRE_W,
  parameter int FB   = FRAC_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          cfg_wr,
  output logic [DVW-1:0] div_last,
  output logic [OW-1:0]  ovs_last,
  output logic [PW-1:0]  pre_code,
  output logic           pre_en
);
  localparam int HI_W = DVW - DW;
  localparam int PHI_W = PW - DW;
  localparam logic [PW-1:0] PRE_MIN = PW'(1 << FB);

  logic [DW-1:0]   div_lo_q, div_lo_d;
  logic [HI_W-1:0] div_hi_q, div_hi_d;
  logic [DW-1:0]   mode_q, mode_d;
  logic [DW-1:0]   index_q, index_d;
  logic [OW-1:0]   ovs_q, ovs_d;
  logic [DW-1:0]   pre_lo_q, pre_lo_d;
  logic [PHI_W-1:0] pre_hi_q, pre_hi_d;
  logic            rd_ok_q, rd_ok_d;
  logic            x_wr;
  logic [DVW-1:0]  div_raw;
  logic [PW-1:0]   pre_raw;

  assign x_wr = wr_en && (addr == A_XDATA);

  always_comb begin
    div_lo_d = div_lo_q;
    div_hi_d = div_hi_q;
    mode_d   = mode_q;
    index_d  = index_q;
    ovs_d    = ovs_q;
    pre_lo_d = pre_lo_q;
    pre_hi_d = pre_hi_q;
    rd_ok_d  = rd_ok_q;
    if (wr_en) begin
      case (addr)
        A_DIV_LO: div_lo_d = wdata;
        A_DIV_HI: div_hi_d = wdata[HI_W-1:0];
        A_MODE:   mode_d   = wdata;
        A_INDEX:  index_d  = wdata;
        default: ;
      endcase
    end
    if (x_wr) begin
      case (index_q)
        X_OVS:    ovs_d = wdata[OW-1:0];
        X_PRE_LO: begin
          pre_lo_d = wdata;
          pre_hi_d = '0;
        end
        X_PRE_HI: pre_hi_d = wdata[PHI_W-1:0];
        X_ACCESS: rd_ok_d  = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo_q <= DW'(1);
      div_hi_q <= '0;
      mode_q   <= '0;
      index_q  <= '0;
      ovs_q    <= '0;
      pre_lo_q <= '0;
      pre_hi_q <= '0;
      rd_ok_q  <= 1'b0;
    end else begin
      div_lo_q <= div_lo_d;
      div_hi_q <= div_hi_d;
      mode_q   <= mode_d;
      index_q  <= index_d;
      ovs_q    <= ovs_d;
      pre_lo_q <= pre_lo_d;
      pre_hi_q <= pre_hi_d;
      rd_ok_q  <= rd_ok_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_DIV_LO: rdata = div_lo_q;
        A_DIV_HI: rdata = DW'(div_hi_q);
        A_MODE:   rdata = mode_q;
        A_INDEX:  rdata = index_q;
        A_XDATA: begin
          if (rd_ok_q) begin
            case (index_q)
              X_OVS:    rdata = DW'(ovs_q);
              X_PRE_LO: rdata = pre_lo_q;
              X_PRE_HI: rdata = DW'(pre_hi_q);
              X_ACCESS: rdata = DW'(rd_ok_q);
              default:  rdata = '0;
            endcase
          end
        end
        default: rdata = '0;
      endcase
    end
  end

  assign cfg_wr = wr_en && ((addr == A_DIV_LO) || (addr == A_DIV_HI) || (addr == A_MODE) ||
                  ((addr == A_XDATA) && (index_q <= X_PRE_HI)));

  assign div_raw  = {div_hi_q, div_lo_q};
  assign div_last = (div_raw == '0) ? '0 : div_raw - DVW'(1);
  assign ovs_last = (ovs_q < OW'(OMIN)) ? '1 : ovs_q - OW'(1);
  assign pre_raw  = {pre_hi_q, pre_lo_q};
  assign pre_code = (pre_raw < PRE_MIN) ? PRE_MIN : pre_raw;
  assign pre_en   = mode_q[MODE_PRE_BIT];

  AST_PRE_HI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (x_wr && index_q == X_PRE_LO) |=> (pre_hi_q == '0)); // R6
endmodule

// File: rtl/frac_baud_prescale.sv
module frac_baud_prescale #(
  parameter int PW = 9,
  parameter int FB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          enable,
  input  logic [PW-1:0] code,
  output logic          tick
);
  localparam int ACC_W = PW + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1 << FB);

  logic [ACC_W-1:0] acc_q, acc_d, sum, code_x;

  assign code_x = {1'b0, code};
  assign sum    = acc_q + STEP;

  always_comb begin
    acc_d = acc_q;
    tick  = 1'b0;
    if (clear) begin
      acc_d = '0;
    end else if (!enable) begin
      acc_d = '0;
      tick  = 1'b1;
    end else if (sum >= code_x) begin
      acc_d = sum - code_x;
      tick  = 1'b1;
    end else begin
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_ACC_BELOW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (acc_q < code_x)); // R3
endmodule

// File: rtl/frac_baud_counter.sv
module frac_baud_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] last_val,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_last;

  assign at_last = (cnt_q == last_val);
  assign wrap    = step && at_last && !clear;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (step)    cnt_d = at_last ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_val); // R7
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int DVW  = DIV_W,
  parameter int OW   = OVS_W,
  parameter int OMIN = OVS_MIN,
  parameter int PW   = PRE_W,
  parameter int FB   = FRAC_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sample_tick,
  output logic          bit_tick
);
  logic           cfg_wr;
  logic [DVW-1:0] div_last;
  logic [OW-1:0]  ovs_last;
  logic [PW-1:0]  pre_code;
  logic           pre_en;
  logic           pre_tick;
  logic           div_wrap;
  logic           sample_q, sample_d;

  frac_baud_regs #(.DW(DW), .AW(AW), .DVW(DVW), .OW(OW), .OMIN(OMIN), .PW(PW), .FB(FB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cfg_wr(cfg_wr), .div_last(div_last), .ovs_last(ovs_last),
    .pre_code(pre_code), .pre_en(pre_en)
  );

  frac_baud_prescale #(.PW(PW), .FB(FB)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(cfg_wr), .enable(pre_en), .code(pre_code), .tick(pre_tick)
  );

  frac_baud_counter #(.W(DVW)) u_div (
    .clk(clk), .rst_n(rst_n), .clear(cfg_wr), .step(pre_tick), .last_val(div_last), .wrap(div_wrap)
  );

  assign sample_d = div_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_q <= 1'b0;
    else        sample_q <= sample_d;
  end

  frac_baud_counter #(.W(OW)) u_ovs (
    .clk(clk), .rst_n(rst_n), .clear(cfg_wr), .step(sample_q), .last_val(ovs_last), .wrap(bit_tick)
  );

  assign sample_tick = sample_q;

  AST_QUIET_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!sample_tick && !bit_tick)); // R9
  AST_SAMPLE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && div_last != '0 && !cfg_wr) |=> !sample_tick); // R7
  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick); // R10
endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sample_tick, bit_tick;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic ext_wr(input logic [7:0] idx, input logic [7:0] d);
    reg_wr(3'd3, idx);
    reg_wr(3'd4, d);
  endtask

  task automatic ext_rd(input logic [7:0] idx, output logic [7:0] d);
    reg_wr(3'd3, idx);
    reg_rd(3'd4, d);
  endtask

  // cycles from the last posedge to the next bit strobe
  task automatic to_bit(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!bit_tick && n < 20000);
  endtask

  // span of k bit periods, samples seen, misaligned bits, min and max period
  task automatic span_bits(input int k, output int span, output int samp, output int bad,
                           output int pmin, output int pmax);
    int n;
    to_bit(n);
    span = 0; samp = 0; bad = 0; pmin = 1 << 30; pmax = 0;
    for (int i = 0; i < k; i++) begin
      int p;
      p = 0;
      do begin
        @(posedge clk); #1;
        p++;
        if (sample_tick) samp++;
        if (bit_tick && !sample_tick) bad++;
      end while (!bit_tick && p < 20000);
      span += p;
      if (p < pmin) pmin = p;
      if (p > pmax) pmax = p;
    end
  endtask

  task automatic set_div(input int d);
    reg_wr(3'd1, 8'(d >> 8));
    reg_wr(3'd0, 8'(d));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int span, samp, bad, pmin, pmax, n;
    repeat (3) @(posedge clk);
    #1 chk(sample_tick == 1'b0 && bit_tick == 1'b0, "R1 ticks low in reset", bit_tick, 0);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    reg_rd(3'd0, rv); chk(rv == 8'd1, "R1 divisor low reset", rv, 1);
    reg_rd(3'd1, rv); chk(rv == 8'd0, "R1 divisor high reset", rv, 0);
    reg_rd(3'd2, rv); chk(rv == 8'd0, "R1 mode reset", rv, 0);
    span_bits(4, span, samp, bad, pmin, pmax);
    chk(span == 64, "R1 reset bit span", span, 64);
    chk(samp == 64, "R1 reset samples per bit", samp, 64);

    // R8 extended reads gated by access bit
    ext_wr(8'd0, 8'd9);
    ext_rd(8'd0, rv); chk(rv == 8'd0, "R8 read without enable", rv, 0);
    ext_wr(8'd3, 8'd1);
    ext_rd(8'd0, rv); chk(rv == 8'd9, "R8 read oversampling", rv, 9);
    reg_rd(3'd3, rv); chk(rv == 8'd0, "R8 index readback", rv, 0);
    @(negedge clk); addr = 3'd0; #1 chk(rdata == 8'd0, "R8 rdata zero without rd_en", rdata, 0);

    // R6 low write clears high
    ext_wr(8'd2, 8'd1);
    ext_rd(8'd2, rv); chk(rv == 8'd1, "R6 high part set", rv, 1);
    ext_wr(8'd1, 8'd20);
    ext_rd(8'd2, rv); chk(rv == 8'd0, "R6 high cleared by low write", rv, 0);
    ext_rd(8'd1, rv); chk(rv == 8'd20, "R6 low part", rv, 20);

    // R2 / R9 / R10: bypass sweep over oversampling codes and divisors
    for (int d = 1; d <= 2; d++) begin
      for (int c = 0; c < 16; c++) begin
        int os;
        os = (c < 4) ? 16 : c;
        set_div(d);
        ext_wr(8'd0, 8'(c));
        chk(sample_tick == 1'b0 && bit_tick == 1'b0, "R9 quiet after write", sample_tick, 0);
        to_bit(n);
        chk(n == d * os, "R9 first bit latency", n, d * os);
        span_bits(4, span, samp, bad, pmin, pmax);
        chk(span == 4 * d * os, "R2 bit span", span, 4 * d * os);
        chk(samp == 4 * os, "R2 samples per bit", samp, 4 * os);
        chk(bad == 0, "R10 bit without sample", bad, 0);
      end
    end

    // R7 divisor values, high byte and zero
    ext_wr(8'd0, 8'd4);
    for (int i = 0; i < 4; i++) begin
      int dv, de;
      dv = (i == 0) ? 0 : (i == 1) ? 3 : (i == 2) ? 257 : 1;
      de = (dv == 0) ? 1 : dv;
      set_div(dv);
      span_bits(2, span, samp, bad, pmin, pmax);
      chk(span == 2 * de * 4, "R7 divisor span", span, 2 * de * 4);
    end

    // R3 / R4 fractional prescaler sweep
    reg_wr(3'd2, 8'h80);
    for (int i = 0; i < 9; i++) begin
      int code, ce;
      code = (i == 0) ? 0 : (i == 1) ? 5 : (i == 2) ? 8 : (i == 3) ? 9 : (i == 4) ? 12 :
             (i == 5) ? 13 : (i == 6) ? 20 : (i == 7) ? 100 : 511;
      ce = (code < 8) ? 8 : code;
      for (int d = 1; d <= 2; d++) begin
        int x;
        x = ce * d * 4;
        set_div(d);
        ext_wr(8'd1, 8'(code));
        ext_wr(8'd2, 8'(code >> 8));
        span_bits(8, span, samp, bad, pmin, pmax);
        if (code < 8)
          chk(span == x, "R4 low code as unity", span, x);
        else
          chk(span == x, "R3 eight-bit span", span, x);
        chk(pmax * 8 - x < 8 && x - pmin * 8 < 8, "R3 per-bit jitter", pmax, x / 8);
        chk(bad == 0, "R10 bit without sample", bad, 0);
      end
    end

    // R5 bypass ignores the prescaler code
    set_div(2);
    ext_wr(8'd1, 8'd20);
    reg_wr(3'd2, 8'h00);
    span_bits(4, span, samp, bad, pmin, pmax);
    chk(span == 4 * 2 * 4, "R5 bypass span", span, 32);
    reg_wr(3'd2, 8'h7f);
    span_bits(4, span, samp, bad, pmin, pmax);
    chk(span == 32, "R5 other mode bits no effect", span, 32);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule